// File: doc/BRIEF.md
# Port-Write Mailbox with Packet-Stored Interrupt

This block is a register-mapped mailbox for maintenance port-write messages. On the send side, software loads up to sixteen 32-bit payload words into a transmit buffer. It then writes a control word that carries a destination ID, a word count and a ready flag. The block streams the words out on a word-wide valid/ready interface that carries start and last markers. The ready flag reads back as set until the final word has been taken.

On the receive side, software first turns reception on. An incoming port-write is then captured word by word into a readable buffer, and its size in bytes is recorded in a status register. A packet-stored bit is set in an interrupt register. The interrupt output is high while that bit is set and its enable bit is on. Software reads the payload and clears the bit by writing a one to it. A port-write that arrives while the bit is still set is dropped, so the stored payload stays intact.

The send side runs a two-state machine. In TX_IDLE, a start command moves it to TX_SEND. In TX_SEND, acceptance of the last word returns it to TX_IDLE; acceptance of any other word advances the word index. The receive side runs a three-state machine. In RX_IDLE, a start beat moves it to RX_RECV when the packet is accepted, or to RX_DROP when it is refused. A start beat that is also the last beat keeps it in RX_IDLE. From RX_RECV and from RX_DROP, the last beat returns it to RX_IDLE.

Top module: `pw_mailbox`

## Requirements
- R1: After reset `tx_valid` and `irq` are 0, and every register reads 0: the offsets 0x080, 0x084, 0x200, 0x250 and 0x254, and both buffers.
- R2: The transmit buffer is 16 words at byte offsets 0x210 + 4·i (i = 0..15). It is writable and reads back what was written.
- R3: The transmit control register at 0x200 holds the ready flag in bit 0, the word count minus one in bits [11:8] and the destination ID in bits [16 +: DEST_W]. DEST_W is 8, or 16 when `DEV_ID_16` = 1. Writing bit 0 = 1 streams words 0..count-1 in order on `tx_data`. `tx_sop` is 1 on the first word only and `tx_eop` on the last only, and `tx_dest` carries the destination ID.
- R4: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data`, `tx_sop` and `tx_eop` hold their values into the next cycle.
- R5: Bit 0 of 0x200 reads 1 from the write that starts a send until the last word is accepted, and reads 0 in the cycle after. While it is 1, writes to the transmit buffer and to 0x200 are ignored.
- R6: Bit 0 of 0x250 enables reception. With it 0, an incoming packet leaves the payload, the size and the packet-stored bit unchanged.
- R7: An accepted packet's words are readable at 0x260 + 4·i. Its size in bytes (4 × words, at most 64) is readable in bits [6:0] of 0x254. Words past the sixteenth are discarded. `rx_ready` is always 1.
- R8: The packet-stored bit is bit 4 of 0x080. It is set in the cycle after the last beat of an accepted packet. Writing 1 to bit 4 clears it, and writing 0 leaves it set.
- R9: Bit 4 of 0x084 enables the interrupt. `irq` is 1 exactly when the stored bit and its enable are both 1.
- R10: A packet that starts while the stored bit is set is dropped, and the stored payload and size are kept.
- R11: Reads of unmapped offsets return 0, and writes to them change no mapped register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| tx_valid | output | 1 | Outgoing word valid |
| tx_ready | input | 1 | Outgoing word accepted |
| tx_sop | output | 1 | First word of outgoing packet |
| tx_eop | output | 1 | Last word of outgoing packet |
| tx_data | output | 32 | Outgoing payload word |
| tx_dest | output | DEST_W | Destination ID of the outgoing packet |
| rx_valid | input | 1 | Incoming word valid |
| rx_ready | output | 1 | Incoming word accepted (always 1) |
| rx_sop | input | 1 | First word of incoming packet |
| rx_eop | input | 1 | Last word of incoming packet |
| rx_data | input | 32 | Incoming payload word |
| irq | output | 1 | Interrupt: stored bit and its enable both set |

## Verification
The bound checker watches, on every cycle, the invariants that need no scenario. These are:
- the outgoing word holds steady under backpressure;
- a new outgoing packet opens with a start marker;
- the ready flag clears in the cycle after the last word is accepted;
- the interrupt is never raised without its enable;
- the recorded size never changes while the stored bit is set.

Other behaviour is shown only by the directed scenarios:
- payload ordering and the destination ID;
- buffer writes ignored during a send;
- truncation of an oversized packet;
- the drop when reception is disabled;
- write-one-to-clear against write-zero;
- unmapped accesses.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int WORD_W    = 32;
    localparam int PAY_WORDS = 16;
    localparam int IDX_W     = $clog2(PAY_WORDS);
    localparam int SIZE_W    = $clog2(PAY_WORDS * 4) + 1;
    localparam int ADDR_W    = 12;
    localparam int STORED_BIT = 4;

    localparam logic [ADDR_W-1:0] A_IRQ_STAT = 12'h080;
    localparam logic [ADDR_W-1:0] A_IRQ_EN   = 12'h084;
    localparam logic [ADDR_W-1:0] A_TX_CTRL  = 12'h200;
    localparam logic [ADDR_W-1:0] A_TX_BUF   = 12'h210;
    localparam logic [ADDR_W-1:0] A_RX_CTRL  = 12'h250;
    localparam logic [ADDR_W-1:0] A_RX_SIZE  = 12'h254;
    localparam logic [ADDR_W-1:0] A_RX_BUF   = 12'h260;

    typedef enum logic [0:0] {TX_IDLE, TX_SEND} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_RECV, RX_DROP} rx_state_t;
endpackage

// File: rtl/pw_tx_engine.sv
module pw_tx_engine
    import pw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] last_idx,
    input  logic             tx_ready,
    output logic             tx_valid,
    output logic             tx_sop,
    output logic             tx_eop,
    output logic             busy,
    output logic [IDX_W-1:0] idx
);
    tx_state_t        state_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                TX_IDLE: if (start) begin
                    state_q <= TX_SEND;
                    idx_q   <= '0;
                end
                TX_SEND: if (tx_ready) begin
                    if (idx_q == last_idx) state_q <= TX_IDLE;
                    else                   idx_q   <= idx_q + 1'b1;
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    always_comb begin
        tx_valid = (state_q == TX_SEND);
        busy     = tx_valid;
        tx_sop   = tx_valid && (idx_q == '0);
        tx_eop   = tx_valid && (idx_q == last_idx);
        idx      = idx_q;
    end
endmodule

// File: rtl/pw_rx_engine.sv
module pw_rx_engine
    import pw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              stored,
    input  logic              rx_valid,
    input  logic              rx_sop,
    input  logic              rx_eop,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              store,
    output logic [SIZE_W-1:0] store_bytes
);
    rx_state_t      state_q;
    logic [IDX_W:0] cnt_q;
    logic [IDX_W:0] cnt_next;
    logic           take;

    assign take = rx_valid && rx_sop && rx_en && !stored;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
        end else if (rx_valid) begin
            unique case (state_q)
                RX_IDLE: if (rx_sop) begin
                    cnt_q <= cnt_next;
                    if (!rx_eop) state_q <= take ? RX_RECV : RX_DROP;
                end
                RX_RECV: begin
                    cnt_q <= cnt_next;
                    if (rx_eop) state_q <= RX_IDLE;
                end
                RX_DROP: if (rx_eop) state_q <= RX_IDLE;
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    always_comb begin
        wr_en    = 1'b0;
        wr_idx   = cnt_q[IDX_W-1:0];
        cnt_next = cnt_q;
        store    = 1'b0;
        unique case (state_q)
            RX_IDLE: begin
                wr_en    = take;
                wr_idx   = '0;
                cnt_next = (IDX_W+1)'(1);
                store    = take && rx_eop;
            end
            RX_RECV: begin
                wr_en    = rx_valid && (cnt_q < (IDX_W+1)'(PAY_WORDS));
                cnt_next = wr_en ? cnt_q + 1'b1 : cnt_q;
                store    = rx_valid && rx_eop;
            end
            RX_DROP: ;
            default: ;
        endcase
        store_bytes = {cnt_next, 2'b00};
    end
endmodule

// File: rtl/pw_mailbox.sv
module pw_mailbox
    import pw_pkg::*;
#(
    parameter bit DEV_ID_16 = 1'b0,
    localparam int DEST_W = DEV_ID_16 ? 16 : 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              tx_sop,
    output logic              tx_eop,
    output logic [WORD_W-1:0] tx_data,
    output logic [DEST_W-1:0] tx_dest,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic              rx_sop,
    input  logic              rx_eop,
    input  logic [WORD_W-1:0] rx_data,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] BUF_SPAN = ADDR_W'(PAY_WORDS * 4);

    logic [WORD_W-1:0] tx_buf [PAY_WORDS];
    logic [WORD_W-1:0] rx_buf [PAY_WORDS];
    logic [DEST_W-1:0] dest_q;
    logic [IDX_W-1:0]  last_q;
    logic              rx_en_q, irq_en_q, stored_q;
    logic [SIZE_W-1:0] rx_size_q;

    logic              busy, start, rx_wr, store, clr;
    logic [IDX_W-1:0]  tx_idx, rx_idx;
    logic [SIZE_W-1:0] store_bytes;
    logic [ADDR_W-1:0] tx_off, rx_off;
    logic              in_tx, in_rx;

    assign tx_off = reg_addr - A_TX_BUF;
    assign rx_off = reg_addr - A_RX_BUF;
    assign in_tx  = (reg_addr >= A_TX_BUF) && (tx_off < BUF_SPAN) && (reg_addr[1:0] == 2'b00);
    assign in_rx  = (reg_addr >= A_RX_BUF) && (rx_off < BUF_SPAN) && (reg_addr[1:0] == 2'b00);
    assign start  = reg_wr && (reg_addr == A_TX_CTRL) && !busy && reg_wdata[0];
    assign clr    = reg_wr && (reg_addr == A_IRQ_STAT) && reg_wdata[STORED_BIT];

    pw_tx_engine u_tx (
        .clk, .rst_n, .start, .last_idx(last_q), .tx_ready,
        .tx_valid, .tx_sop, .tx_eop, .busy, .idx(tx_idx)
    );

    pw_rx_engine u_rx (
        .clk, .rst_n, .rx_en(rx_en_q), .stored(stored_q), .rx_valid,
        .rx_sop, .rx_eop, .wr_en(rx_wr), .wr_idx(rx_idx),
        .store, .store_bytes
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_q    <= '0;
            last_q    <= '0;
            rx_en_q   <= 1'b0;
            irq_en_q  <= 1'b0;
            stored_q  <= 1'b0;
            rx_size_q <= '0;
        end else begin
            if (reg_wr && !busy && reg_addr == A_TX_CTRL) begin
                dest_q <= reg_wdata[16 +: DEST_W];
                last_q <= reg_wdata[8 +: IDX_W];
            end
            if (reg_wr && reg_addr == A_RX_CTRL) rx_en_q  <= reg_wdata[0];
            if (reg_wr && reg_addr == A_IRQ_EN)  irq_en_q <= reg_wdata[STORED_BIT];
            stored_q <= store | (stored_q & ~clr);
            if (store) rx_size_q <= store_bytes;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < PAY_WORDS; gi++) begin : g_buf
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tx_buf[gi] <= '0;
                    rx_buf[gi] <= '0;
                end else begin
                    if (reg_wr && !busy && in_tx && tx_off[IDX_W+1:2] == IDX_W'(gi))
                        tx_buf[gi] <= reg_wdata;
                    if (rx_wr && rx_idx == IDX_W'(gi))
                        rx_buf[gi] <= rx_data;
                end
            end
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        if (in_tx) begin
            reg_rdata = tx_buf[tx_off[IDX_W+1:2]];
        end else if (in_rx) begin
            reg_rdata = rx_buf[rx_off[IDX_W+1:2]];
        end else begin
            unique case (reg_addr)
                A_IRQ_STAT: reg_rdata[STORED_BIT] = stored_q;
                A_IRQ_EN:   reg_rdata[STORED_BIT] = irq_en_q;
                A_TX_CTRL: begin
                    reg_rdata[0]            = busy;
                    reg_rdata[8 +: IDX_W]   = last_q;
                    reg_rdata[16 +: DEST_W] = dest_q;
                end
                A_RX_CTRL:  reg_rdata[0] = rx_en_q;
                A_RX_SIZE:  reg_rdata[SIZE_W-1:0] = rx_size_q;
                default:    reg_rdata = '0;
            endcase
        end
    end

    assign tx_data  = tx_buf[tx_idx];
    assign tx_dest  = dest_q;
    assign rx_ready = 1'b1;
    assign irq      = stored_q & irq_en_q;
endmodule

// File: rtl/pw_mailbox_chk.sv
module pw_mailbox_chk
    import pw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              tx_sop,
    input logic              tx_eop,
    input logic [WORD_W-1:0] tx_data,
    input logic              busy,
    input logic              irq,
    input logic              irq_en,
    input logic              stored,
    input logic [SIZE_W-1:0] rx_size
);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop));

    p_first_sop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> tx_sop);

    p_ready_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && tx_eop |=> !busy);

    p_irq_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en && stored);

    p_size_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stored |=> $stable(rx_size));
endmodule

bind pw_mailbox pw_mailbox_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_data(tx_data), .busy(busy),
    .irq(irq), .irq_en(irq_en_q), .stored(stored_q), .rx_size(rx_size_q)
);

// File: tb/tb_pw_mailbox.sv
module tb_pw_mailbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_valid, tx_sop, tx_eop;
    logic        tx_ready = 1'b0;
    logic [31:0] tx_data;
    logic [7:0]  tx_dest;
    logic        rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
    logic        rx_ready;
    logic [31:0] rx_data = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pw_mailbox dut (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic expect_reg(input logic [11:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        reg_read(a, v);
        check(v == exp, req, $sformatf("read %h", a), v, exp);
    endtask

    task automatic rx_send(input int n, input logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sop = (i == 0); rx_eop = (i == n - 1);
            rx_data = base + 32'(i);
            @(posedge clk);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(tx_valid == 1'b0, "R1", "tx_valid", 32'(tx_valid), 0);
        check(irq == 1'b0, "R1", "irq", 32'(irq), 0);
        expect_reg(12'h080, 0, "R1");
        expect_reg(12'h084, 0, "R1");
        expect_reg(12'h200, 0, "R1");
        expect_reg(12'h250, 0, "R1");
        expect_reg(12'h254, 0, "R1");
        expect_reg(12'h210, 0, "R1");
        expect_reg(12'h260, 0, "R1");
    endtask

    task automatic t_tx_send(input int n, input bit stall);
        int k = 0;
        for (int i = 0; i < n; i++) reg_write(12'h210 + 12'(4 * i), 32'hA000_0000 + 32'(i) + 32'(n << 8));
        expect_reg(12'h210 + 12'(4 * (n - 1)), 32'hA000_0000 + 32'(n - 1) + 32'(n << 8), "R2");
        tx_ready = 1'b0;
        reg_write(12'h200, 32'h0055_0001 | (32'(n - 1) << 8));
        expect_reg(12'h200, 32'h0055_0001 | (32'(n - 1) << 8), "R5 busy");
        if (stall) begin
            reg_write(12'h210, 32'hDEAD_BEEF);
            reg_write(12'h200, 32'h0066_0F01);
            expect_reg(12'h210, 32'hA000_0000 + 32'(n << 8), "R5 buffer write ignored");
            check(tx_dest == 8'h55, "R5", "dest write ignored", 32'(tx_dest), 32'h55);
            check(tx_valid && tx_data == 32'hA000_0000 + 32'(n << 8), "R4", "held word",
                  tx_data, 32'hA000_0000 + 32'(n << 8));
        end
        for (int c = 0; c < 80 && k < n; c++) begin
            @(negedge clk);
            tx_ready = stall ? c[0] : 1'b1;
            #1;
            if (tx_valid && tx_ready) begin
                check(tx_data == 32'hA000_0000 + 32'(k) + 32'(n << 8), "R3", "tx word",
                      tx_data, 32'hA000_0000 + 32'(k) + 32'(n << 8));
                check(tx_sop == (k == 0) && tx_eop == (k == n - 1), "R3", "sop/eop",
                      {30'd0, tx_sop, tx_eop}, {30'd0, k == 0, k == n - 1});
                check(tx_dest == 8'h55, "R3", "tx_dest", 32'(tx_dest), 32'h55);
                k++;
            end
            @(posedge clk);
        end
        @(negedge clk);
        tx_ready = 1'b0;
        check(k == n, "R3", "word count", k, n);
        check(!tx_valid, "R5", "valid after last", 32'(tx_valid), 0);
        expect_reg(12'h200, 32'h0055_0000 | (32'(n - 1) << 8), "R5 ready cleared");
    endtask

    task automatic t_rx_basic;
        reg_write(12'h084, 32'h10);
        reg_write(12'h250, 32'h1);
        rx_send(5, 32'hB000_0000);
        check(irq == 1'b1, "R9", "irq after store", 32'(irq), 1);
        expect_reg(12'h080, 32'h10, "R8 stored");
        expect_reg(12'h254, 32'd20, "R7 size");
        for (int i = 0; i < 5; i++) expect_reg(12'h260 + 12'(4 * i), 32'hB000_0000 + 32'(i), "R7 payload");
    endtask

    task automatic t_rx_while_stored;
        rx_send(3, 32'hC000_0000);
        expect_reg(12'h254, 32'd20, "R10 size kept");
        expect_reg(12'h260, 32'hB000_0000, "R10 payload kept");
        reg_write(12'h080, 32'h0);
        expect_reg(12'h080, 32'h10, "R8 write zero keeps bit");
        reg_write(12'h080, 32'h10);
        expect_reg(12'h080, 32'h0, "R8 w1c");
        check(irq == 1'b0, "R9", "irq after clear", 32'(irq), 0);
    endtask

    task automatic t_irq_masked;
        reg_write(12'h084, 32'h0);
        rx_send(1, 32'hD000_0000);
        expect_reg(12'h080, 32'h10, "R9 stored while masked");
        check(irq == 1'b0, "R9", "irq masked", 32'(irq), 0);
        expect_reg(12'h254, 32'd4, "R7 single word size");
        reg_write(12'h084, 32'h10);
        check(irq == 1'b1, "R9", "irq on enable", 32'(irq), 1);
        reg_write(12'h080, 32'h10);
    endtask

    task automatic t_rx_disabled;
        reg_write(12'h250, 32'h0);
        rx_send(2, 32'hE000_0000);
        expect_reg(12'h080, 32'h0, "R6 no store");
        expect_reg(12'h254, 32'd4, "R6 size unchanged");
        expect_reg(12'h260, 32'hD000_0000, "R6 payload unchanged");
        check(irq == 1'b0, "R6", "irq", 32'(irq), 0);
        reg_write(12'h250, 32'h1);
    endtask

    task automatic t_rx_oversize;
        rx_send(18, 32'hF000_0000);
        expect_reg(12'h254, 32'd64, "R7 truncated size");
        expect_reg(12'h29C, 32'hF000_000F, "R7 last kept word");
        expect_reg(12'h260, 32'hF000_0000, "R7 first word");
        reg_write(12'h080, 32'h10);
    endtask

    task automatic t_unmapped;
        reg_write(12'h300, 32'hFFFF_FFFF);
        reg_write(12'h088, 32'hFFFF_FFFF);
        expect_reg(12'h300, 0, "R11 unmapped read");
        expect_reg(12'h088, 0, "R11 unmapped read");
        expect_reg(12'h084, 32'h10, "R11 enable unchanged");
        expect_reg(12'h080, 32'h0, "R11 status unchanged");
        expect_reg(12'h250, 32'h1, "R11 rx enable unchanged");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tx_send(5, 1'b1);
        t_tx_send(16, 1'b0);
        t_rx_basic();
        t_rx_while_stored();
        t_irq_masked();
        t_rx_disabled();
        t_rx_oversize();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule